// File: doc/BRIEF.md
# Block Address Translation Unit

This unit translates the upper part of a 32-bit effective address to a physical block address for large, contiguous regions of memory. It holds eight translation entries that are all compared in parallel against each lookup address. Each entry sets its own region size, any power of two from 128 KB to 256 MB. Each entry also returns protection and cache-control attributes for the region it covers. A lookup that hits here tells the page-based translation path to abandon its own result.

Software programs each entry as two 32-bit words through a simple write port. The lookup side is purely combinational over the stored entries. It takes the address, the privilege of the access, whether the access is a store, and a translation-enable bit. When translation is off, the address passes through untouched.

Top module: `bat_xlate`

## Requirements
- R1: A synchronous active-high reset clears every entry, so that no lookup hits until an entry is programmed again.
- R2: A write with `wr_hi`=1 sets the entry's upper word: bits 31:17 are the effective block base, bits 12:2 are the size mask, bit 1 is supervisor-valid and bit 0 is user-valid. A write with `wr_hi`=0 sets the lower word: bits 31:17 are the physical block base, bits 6:3 are the attributes and bits 1:0 are the protection code. All other bits are ignored.
- R3: Size-mask bit k removes effective-address bit 17+k from the compare. An all-zero mask gives a 128 KB block and an all-ones mask gives a 256 MB block.
- R4: On a hit, `pa[16:0]` equals `lk_ea[16:0]`. Each bit of `pa[31:17]` comes from the effective address where the mask covers it, and from the physical base elsewhere.
- R5: An entry can hit only if the valid bit for the access privilege is set: user-valid when `lk_user`=1, supervisor-valid when `lk_user`=0.
- R6: `pt_cancel` is high exactly when a translated lookup hits.
- R7: When `lk_xlate_en`=0, `pa` equals `lk_ea`, and `hit`, `pt_cancel`, `multi_hit`, `prot_fault` and `attr` are all zero. A lookup that misses also returns `pa`=`lk_ea`.
- R8: `multi_hit` is high when two or more entries match. The lowest-numbered matching entry then supplies the result.
- R9: The protection codes are 00 no access, 01 read-only, and 10 or 11 read-write. `prot_fault` is high on a hit to a no-access block, or on a store (`lk_write`=1) that hits a read-only block.
- R10: A write takes effect at the next rising clock edge. A lookup in the same cycle as the write sees the old contents.
- R11: On a hit, `attr` carries the matching entry's attributes. Otherwise `attr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for entry programming |
| wr_idx | input | 3 | Entry number to write |
| wr_hi | input | 1 | 1 selects the upper word, 0 selects the lower word |
| wr_data | input | 32 | Word to write |
| lk_ea | input | 32 | Effective address of the lookup |
| lk_user | input | 1 | 1 for user privilege, 0 for supervisor |
| lk_write | input | 1 | 1 when the access is a store |
| lk_xlate_en | input | 1 | Translation enable; 0 selects the real-mode bypass |
| hit | output | 1 | Some entry translated the address |
| pt_cancel | output | 1 | Tells the page-translation path to abandon its result |
| pa | output | 32 | Physical address |
| attr | output | 4 | Cache-control attributes of the matching entry |
| prot_fault | output | 1 | Access violates the block protection |
| multi_hit | output | 1 | More than one entry matched |

## Verification
The bench builds the unit with its default parameters: eight entries and an 11-bit size mask over a 32-bit address. With these values every block size from 128 KB to 256 MB can be reached. Random lookups are aimed at programmed bases, with random bits flipped inside and outside each mask, so the masked compare is exercised at every size. Overlapping entries are also reachable at this depth, which exercises the multi-hit path and its lowest-index priority.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int EA_W    = 32;
    localparam int BLK_LSB = 17;
    localparam int BLK_W   = EA_W - BLK_LSB;
    localparam int LEN_W   = 11;
    localparam int ATTR_W  = 4;
    localparam int WORD_W  = 32;

    typedef enum logic [1:0] {
        PROT_NONE = 2'b00,
        PROT_RO   = 2'b01,
        PROT_RW   = 2'b10,
        PROT_RWX  = 2'b11
    } prot_e;

    typedef struct packed {
        logic [BLK_W-1:0]  ebase;
        logic [LEN_W-1:0]  lmask;
        logic              sv;
        logic              uv;
        logic [BLK_W-1:0]  pbase;
        logic [ATTR_W-1:0] attr;
        prot_e             prot;
    } bat_entry_t;

    // widen the size mask to the block-address width
    function automatic logic [BLK_W-1:0] widen_mask(input logic [LEN_W-1:0] m);
        return {{(BLK_W-LEN_W){1'b0}}, m};
    endfunction

    function automatic bat_entry_t load_upper(input bat_entry_t e, input logic [WORD_W-1:0] d);
        bat_entry_t r = e;
        r.ebase = d[31:17];
        r.lmask = d[12:2];
        r.sv    = d[1];
        r.uv    = d[0];
        return r;
    endfunction

    function automatic bat_entry_t load_lower(input bat_entry_t e, input logic [WORD_W-1:0] d);
        bat_entry_t r = e;
        r.pbase = d[31:17];
        r.attr  = d[6:3];
        r.prot  = prot_e'(d[1:0]);
        return r;
    endfunction
endpackage

// File: rtl/bat_store.sv
module bat_store
    import bat_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic                     wr_hi,
    input  logic [WORD_W-1:0]        wr_data,
    output bat_entry_t [N-1:0]       ent
);
    // reserved word bits are accepted and dropped
    logic unused_rsv;
    assign unused_rsv = ^{wr_data[16:13], wr_data[16:7], wr_data[2]};

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                if (wr_hi) ent[g] <= load_upper(ent[g], wr_data);
                else       ent[g] <= load_lower(ent[g], wr_data);
            end
        end
    end
endmodule

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
#(
    parameter int N = 8
) (
    input  bat_entry_t [N-1:0] ent,
    input  logic [BLK_W-1:0]   ea_blk,
    input  logic               user,
    output logic [N-1:0]       match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [BLK_W-1:0] care;
        logic             same;
        logic             vld;
        assign care     = ~widen_mask(ent[g].lmask);
        assign same     = ((ea_blk ^ ent[g].ebase) & care) == '0;
        assign vld      = user ? ent[g].uv : ent[g].sv;
        assign match[g] = same && vld;
    end
endmodule

// File: rtl/bat_select.sv
module bat_select
    import bat_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  bat_entry_t [N-1:0] ent,
    input  logic [N-1:0]       match,
    input  logic [BLK_W-1:0]   ea_blk,
    output logic               any,
    output logic               many,
    output logic [BLK_W-1:0]   pa_blk,
    output logic [ATTR_W-1:0]  attr,
    output prot_e              prot
);
    logic [IW-1:0]    sel_idx;
    bat_entry_t       sel;
    logic [BLK_W-1:0] keep;

    // lowest index wins
    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel_idx = i[IW-1:0];
        end
    end

    assign sel    = ent[sel_idx];
    assign any    = |match;
    assign many   = $countones(match) > 1;
    assign keep   = widen_mask(sel.lmask);
    assign pa_blk = (sel.pbase & ~keep) | (ea_blk & keep);
    assign attr   = sel.attr;
    assign prot   = sel.prot;
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW   = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [EA_W-1:0]   lk_ea,
    input  logic              lk_user,
    input  logic              lk_write,
    input  logic              lk_xlate_en,
    output logic              hit,
    output logic              pt_cancel,
    output logic [EA_W-1:0]   pa,
    output logic [ATTR_W-1:0] attr,
    output logic              prot_fault,
    output logic              multi_hit
);
    bat_entry_t [N_ENT-1:0] ent;
    logic [N_ENT-1:0]       match;
    logic                   any, many;
    logic [BLK_W-1:0]       pa_blk;
    logic [ATTR_W-1:0]      sel_attr;
    prot_e                  sel_prot;
    logic [BLK_W-1:0]       ea_blk;

    assign ea_blk = lk_ea[EA_W-1:BLK_LSB];

    bat_store #(.N(N_ENT), .IW(IW)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_data(wr_data), .ent(ent)
    );

    bat_match #(.N(N_ENT)) u_match (
        .ent(ent), .ea_blk(ea_blk), .user(lk_user), .match(match)
    );

    bat_select #(.N(N_ENT), .IW(IW)) u_sel (
        .ent(ent), .match(match), .ea_blk(ea_blk), .any(any), .many(many),
        .pa_blk(pa_blk), .attr(sel_attr), .prot(sel_prot)
    );

    always_comb begin
        hit        = lk_xlate_en && any;
        pt_cancel  = hit;
        multi_hit  = lk_xlate_en && many;
        pa         = hit ? {pa_blk, lk_ea[BLK_LSB-1:0]} : lk_ea;
        attr       = hit ? sel_attr : '0;
        prot_fault = hit && ((sel_prot == PROT_NONE) ||
                             (sel_prot == PROT_RO && lk_write));
    end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
    import bat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EA_W-1:0]   lk_ea,
    input logic              lk_xlate_en,
    input logic              hit,
    input logic              pt_cancel,
    input logic [EA_W-1:0]   pa,
    input logic [ATTR_W-1:0] attr,
    input logic              prot_fault,
    input logic              multi_hit
);
    AST_REAL_PASS: assert property (@(posedge clk) disable iff (rst)
        !lk_xlate_en |-> (pa == lk_ea && !hit && !multi_hit)); // R7
    AST_CANCEL_NEEDS_XLATE: assert property (@(posedge clk) disable iff (rst)
        pt_cancel |-> lk_xlate_en); // R6
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        pa[BLK_LSB-1:0] == lk_ea[BLK_LSB-1:0]); // R4
    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> hit); // R9
    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        multi_hit |-> hit); // R8
    AST_ATTR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !hit |-> attr == '0); // R11
endmodule

bind bat_xlate bat_xlate_chk u_chk (.*);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
    localparam int PERIOD = 10;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0, wr_hi = 0;
    logic [2:0]  wr_idx = 0;
    logic [31:0] wr_data = 0, lk_ea = 0;
    logic        lk_user = 0, lk_write = 0, lk_xlate_en = 0;
    logic        hit, pt_cancel, prot_fault, multi_hit;
    logic [31:0] pa;
    logic [3:0]  attr;

    int n_tests = 0, n_fail = 0;
    logic [31:0] sh_hi [8];
    logic [31:0] sh_lo [8];

    bat_xlate uut (.*);

    always #(PERIOD/2) clk = ~clk;

    initial begin
        #(PERIOD*150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [31:0] mk_hi(logic [14:0] eb, logic [10:0] lm, bit sv, bit uv);
        return {eb, 4'b0, lm, sv, uv};
    endfunction
    function automatic logic [31:0] mk_lo(logic [14:0] pb, logic [3:0] at, logic [1:0] pr);
        return {pb, 10'b0, at, 1'b0, pr};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected-value model built from the requirements
    task automatic expect_all(string req);
        int cnt = 0, first = -1;
        logic [14:0] eb, lm15, keep;
        logic [31:0] e_pa;
        logic [3:0]  e_attr;
        bit e_hit, e_fault;
        for (int i = 0; i < 8; i++) begin
            eb   = sh_hi[i][31:17];
            lm15 = {4'b0, sh_hi[i][12:2]};
            if ((lk_user ? sh_hi[i][0] : sh_hi[i][1]) &&
                (((lk_ea[31:17] ^ eb) & ~lm15) == 0)) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        e_hit = lk_xlate_en && cnt > 0;
        e_pa = lk_ea; e_attr = 0; e_fault = 0;
        if (e_hit) begin
            keep   = {4'b0, sh_hi[first][12:2]};
            e_pa   = {(sh_lo[first][31:17] & ~keep) | (lk_ea[31:17] & keep), lk_ea[16:0]};
            e_attr = sh_lo[first][6:3];
            e_fault = (sh_lo[first][1:0] == 2'b00) ||
                      (sh_lo[first][1:0] == 2'b01 && lk_write);
        end
        chk(req, "hit", 32'(hit), 32'(e_hit));
        chk(req, "pt_cancel R6", 32'(pt_cancel), 32'(e_hit));
        chk(req, "pa", pa, e_pa);
        chk(req, "attr R11", 32'(attr), 32'(e_attr));
        chk(req, "prot_fault", 32'(prot_fault), 32'(e_fault));
        chk(req, "multi_hit", 32'(multi_hit), 32'(lk_xlate_en && cnt > 1));
    endtask

    task automatic do_write(int idx, bit hi, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_hi = hi; wr_data = d;
        @(posedge clk); #1;
        if (hi) sh_hi[idx] = d; else sh_lo[idx] = d;
        wr_en = 0;
    endtask

    task automatic look(logic [31:0] ea, bit user, bit wr, bit en, string req);
        @(negedge clk);
        lk_ea = ea; lk_user = user; lk_write = wr; lk_xlate_en = en;
        #1;
        expect_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) begin sh_hi[i] = 0; sh_lo[i] = 0; end
        @(negedge clk); rst = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) begin sh_hi[i] = 0; sh_lo[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: nothing hits out of reset
        look(32'h0200_1234, 0, 0, 1, "R1");
        look(32'h0000_0000, 1, 0, 1, "R1");

        // R2 R3 R4: 128 KB block
        do_write(0, 1, mk_hi(15'h0100, 11'h000, 1, 1));
        do_write(0, 0, mk_lo(15'h7000, 4'hA, 2'b10) | 32'h0001_FF84);
        look({15'h0100, 17'h1ABCD}, 0, 1, 1, "R2_R4");
        look({15'h0101, 17'h00001}, 0, 0, 1, "R3");

        // R3 R5 R9: 256 MB read-only block, supervisor only
        do_write(1, 1, mk_hi(15'h0800, 11'h7FF, 1, 0));
        do_write(1, 0, mk_lo(15'h2000, 4'h5, 2'b01));
        look(32'h1234_5678, 0, 0, 1, "R3");
        look(32'h1FFF_FFFC, 0, 1, 1, "R9");
        look(32'h2000_0000, 0, 0, 1, "R3");
        look(32'h1234_5678, 1, 0, 1, "R5");

        // R9 no-access block, user only
        do_write(2, 1, mk_hi(15'h4000, 11'h00F, 0, 1));
        do_write(2, 0, mk_lo(15'h1230, 4'h3, 2'b00));
        look(32'h801E_0000, 1, 0, 1, "R9");
        look(32'h801E_0000, 0, 0, 1, "R5");

        // R8: overlap with entry 0, lowest index wins
        do_write(3, 1, mk_hi(15'h0100, 11'h003, 1, 1));
        do_write(3, 0, mk_lo(15'h0F00, 4'h1, 2'b00));
        look({15'h0100, 17'h00042}, 0, 0, 1, "R8");
        look({15'h0102, 17'h00042}, 0, 0, 1, "R8");

        // R7: real-mode bypass
        look({15'h0100, 17'h1ABCD}, 0, 1, 0, "R7");
        look(32'h1234_5678, 0, 1, 0, "R7");

        // R10: same-cycle write sees old contents, then new
        @(negedge clk);
        wr_en = 1; wr_idx = 0; wr_hi = 1; wr_data = 32'h0;
        lk_ea = {15'h0100, 17'h00010}; lk_user = 0; lk_write = 0; lk_xlate_en = 1;
        #1; expect_all("R10");
        @(posedge clk); #1; sh_hi[0] = 32'h0; wr_en = 0;
        look({15'h0100, 17'h00010}, 0, 0, 1, "R10");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int e;
            logic [14:0] flip;
            if ($urandom_range(3) == 0) begin
                do_write($urandom_range(7), 1,
                         mk_hi(15'($urandom), 11'((1 << $urandom_range(11)) - 1),
                               bit'($urandom), bit'($urandom)));
                do_write($urandom_range(7), 0,
                         mk_lo(15'($urandom), 4'($urandom), 2'($urandom)));
            end
            e = $urandom_range(7);
            flip = ($urandom_range(3) == 0) ? 15'($urandom) : {4'b0, 11'($urandom) & sh_hi[e][12:2]};
            look({sh_hi[e][31:17] ^ flip, 17'($urandom)}, bit'($urandom), bit'($urandom),
                 $urandom_range(7) != 0, "R3_R4_R5_R8_R9");
        end

        // R1: reset wipes programmed entries
        do_write(5, 1, mk_hi(15'h3333, 11'h000, 1, 1));
        do_write(5, 0, mk_lo(15'h1111, 4'hF, 2'b11));
        look({15'h3333, 17'h0}, 0, 0, 1, "R1");
        do_reset();
        look({15'h3333, 17'h0}, 0, 0, 1, "R1");
        look({15'h3333, 17'h0}, 1, 0, 1, "R1");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule